// File: doc/BRIEF.md
# Hardware Breakpoint and Watchpoint Unit

This block sits beside a processor core and decides, every cycle, whether the core must be stopped. It compares the program counter against a bank of instruction address comparators and the data-access bus against a bank of access comparators. It also watches a set of external event lines. When any enabled source fires, it raises a halt request in that same cycle, so the run-control logic can freeze the core on exactly the matching instruction or access. A match index names the source that caused the stop.

Two halt-source stages can be chained: a sequencer waits for a chosen first source, arms, and then halts only when a chosen second source fires. Configuration arrives through a simple register-write port that loads compare addresses, compare values, access-type controls, per-source enables and the sequencer setup. While the core reports that it is stopped, every source is blind, so a stale program counter or bus value cannot re-trigger.

Top module: `bkpt_watch_unit`

## Requirements
- R1: When the program counter equals the compare address of instruction comparator i and enable bit i is set, halt_req is high in that same cycle and halt_idx reads i.
- R2: A source whose enable bit is clear never raises halt_req on its own, even when its compare condition is true.
- R3: Each access comparator has a 2-bit access field (bits 1:0 of its control register): 01 matches reads only, 10 writes only, 11 either, 00 never; it also needs the data address to equal its compare address.
- R4: When the value-compare bit (bit 2 of the control register) is set, an access comparator matches only if the data value also equals its compare value; when clear, the data value is ignored.
- R5: Each external event line k raises halt_req when its enable bit is set, reporting the index after all instruction and access comparators.
- R6: With the sequencer enabled, a hit on source A sets an armed flag in the next cycle; a later hit on source B while armed raises halt_req with halt_idx equal to the total count of instruction, access and event sources. A and B together while not armed produce no halt, and A and B need not be enabled for direct halts.
- R7: The armed flag clears in the cycle after any halt_req and in the cycle after a write to the sequencer register.
- R8: When several sources fire in one cycle, halt_idx reports the lowest index; source indices are ordered instruction comparators, then access comparators, then event lines, then the sequencer.
- R9: While core_stopped is high, no source hits: halt_req stays low and the sequencer cannot arm.
- R10: After reset every compare register, control field, enable and the armed flag are zero; halt_req is low and halt_idx is zero whenever no halt is raised.
- R11: A write with cfg_we high updates state from the next cycle on, at these offsets: 0x00+i instruction address i, 0x10+j access address j, 0x14+j access value j, 0x18+j access control j, 0x20 enable mask (bit = source index), 0x21 sequencer (bit 0 enable, bits 12:8 source A, bits 20:16 source B).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_stopped | input | 1 | Core is halted; all sources are ignored |
| pc | input | PC_W | Program counter of the instruction in the current cycle |
| dacc_addr | input | DA_W | Data access address |
| dacc_data | input | DV_W | Data access value |
| dacc_rd | input | 1 | Data read strobe |
| dacc_wr | input | 1 | Data write strobe |
| ext_evt | input | N_EVT | External event lines |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration register offset |
| cfg_wdata | input | 32 | Configuration write data |
| halt_req | output | 1 | Halt request, same cycle as the match |
| halt_idx | output | IDX_W | Index of the lowest firing source |

## Verification
The bench drives duplicate comparator addresses and mixed-class coincidences to catch an encoder that reports the highest or the last index instead of the lowest. It walks each access-type code in both directions, where a swapped bit would halt on a write for a read-only watch. Sequencer tests aim at a flag that arms in the same cycle as A (halting on simultaneous A and B), one that survives a halt or a sequencer rewrite (halting a second time on B alone), and one that arms while the core is stopped. A stopped core with a matching program counter shows whether the comparators were gated.

// File: rtl/bwu_pkg.sv
package bwu_pkg;

    localparam int CFG_AW = 8;
    localparam int CFG_DW = 32;

    localparam logic [CFG_AW-1:0] OFS_ICMP  = 8'h00;
    localparam logic [CFG_AW-1:0] OFS_WADDR = 8'h10;
    localparam logic [CFG_AW-1:0] OFS_WVAL  = 8'h14;
    localparam logic [CFG_AW-1:0] OFS_WCTL  = 8'h18;
    localparam logic [CFG_AW-1:0] OFS_EN    = 8'h20;
    localparam logic [CFG_AW-1:0] OFS_SEQ   = 8'h21;

    typedef enum logic [1:0] {
        ACC_NONE = 2'b00,
        ACC_RD   = 2'b01,
        ACC_WR   = 2'b10,
        ACC_ANY  = 2'b11
    } acc_e;

    typedef struct packed {
        logic vce;
        acc_e acc;
    } wctl_t;

endpackage

// File: rtl/bwu_inst_match.sv
module bwu_inst_match #(
    parameter int N = 4,
    parameter int W = 32
) (
    input  logic [N-1:0][W-1:0] cmp_addr,
    input  logic [W-1:0]        pc,
    input  logic                stopped,
    output logic [N-1:0]        hit
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit[g] = ~stopped & (pc == cmp_addr[g]);
    end
endmodule

// File: rtl/bwu_data_match.sv
module bwu_data_match
    import bwu_pkg::*;
#(
    parameter int N  = 2,
    parameter int AW = 32,
    parameter int VW = 32
) (
    input  logic [N-1:0][AW-1:0] cmp_addr,
    input  logic [N-1:0][VW-1:0] cmp_val,
    input  wctl_t [N-1:0]        ctl,
    input  logic [AW-1:0]        addr,
    input  logic [VW-1:0]        data,
    input  logic                 rd,
    input  logic                 wr,
    input  logic                 stopped,
    output logic [N-1:0]         hit
);
    for (genvar g = 0; g < N; g++) begin : g_wp
        logic dir_ok;
        logic val_ok;
        assign dir_ok = (rd & ctl[g].acc[0]) | (wr & ctl[g].acc[1]);
        assign val_ok = ~ctl[g].vce | (data == cmp_val[g]);
        assign hit[g] = ~stopped & dir_ok & val_ok & (addr == cmp_addr[g]);
    end
endmodule

// File: rtl/bwu_prio.sv
module bwu_prio #(
    parameter int W  = 9,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  req,
    output logic          valid,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int k = W - 1; k >= 0; k--) begin
            if (req[k]) idx = IW'(k);
        end
    end
    assign valid = |req;
endmodule

// File: rtl/bkpt_watch_unit.sv
module bkpt_watch_unit
    import bwu_pkg::*;
#(
    parameter int N_ICMP  = 4,
    parameter int N_WATCH = 2,
    parameter int N_EVT   = 2,
    parameter int PC_W    = 32,
    parameter int DA_W    = 32,
    parameter int DV_W    = 32,
    localparam int N_BASE  = N_ICMP + N_WATCH + N_EVT,
    localparam int N_SRC   = N_BASE + 1,
    localparam int IDX_W   = $clog2(N_SRC),
    localparam int WP_BASE = N_ICMP,
    localparam int EV_BASE = N_ICMP + N_WATCH,
    localparam int SEQ_IDX = N_BASE,
    localparam int PAD_N   = (1 << IDX_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_stopped,
    input  logic [PC_W-1:0]   pc,
    input  logic [DA_W-1:0]   dacc_addr,
    input  logic [DV_W-1:0]   dacc_data,
    input  logic              dacc_rd,
    input  logic              dacc_wr,
    input  logic [N_EVT-1:0]  ext_evt,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    output logic              halt_req,
    output logic [IDX_W-1:0]  halt_idx
);

    typedef struct packed {
        logic [N_ICMP-1:0][PC_W-1:0]  icmp;
        logic [N_WATCH-1:0][DA_W-1:0] waddr;
        logic [N_WATCH-1:0][DV_W-1:0] wval;
        wctl_t [N_WATCH-1:0]          wctl;
        logic [N_BASE-1:0]            en;
        logic                         seq_en;
        logic [IDX_W-1:0]             seq_a;
        logic [IDX_W-1:0]             seq_b;
        logic                         armed;
    } state_t;

    state_t s_d, s_q;

    logic [N_ICMP-1:0]  ihit;
    logic [N_WATCH-1:0] whit;
    logic [N_BASE-1:0]  hit_base;
    logic [PAD_N-1:0]   hit_pad;
    logic               seq_fire;
    logic [N_SRC-1:0]   fire_vec;
    logic               unused_cfg_bits;

    assign unused_cfg_bits = &{1'b0, cfg_wdata};

    bwu_inst_match #(.N(N_ICMP), .W(PC_W)) i_inst (
        .cmp_addr (s_q.icmp),
        .pc       (pc),
        .stopped  (core_stopped),
        .hit      (ihit)
    );

    bwu_data_match #(.N(N_WATCH), .AW(DA_W), .VW(DV_W)) i_data (
        .cmp_addr (s_q.waddr),
        .cmp_val  (s_q.wval),
        .ctl      (s_q.wctl),
        .addr     (dacc_addr),
        .data     (dacc_data),
        .rd       (dacc_rd),
        .wr       (dacc_wr),
        .stopped  (core_stopped),
        .hit      (whit)
    );

    assign hit_base[WP_BASE-1:0]       = ihit;
    assign hit_base[WP_BASE +: N_WATCH] = whit;
    assign hit_base[EV_BASE +: N_EVT]   = ext_evt & {N_EVT{~core_stopped}};
    assign hit_pad  = {{(PAD_N - N_BASE){1'b0}}, hit_base};
    assign seq_fire = s_q.seq_en & s_q.armed & hit_pad[s_q.seq_b];
    assign fire_vec = {seq_fire, hit_base & s_q.en};

    bwu_prio #(.W(N_SRC), .IW(IDX_W)) i_prio (
        .req   (fire_vec),
        .valid (halt_req),
        .idx   (halt_idx)
    );

    always_comb begin
        s_d = s_q;
        if (cfg_we && cfg_addr == OFS_SEQ) begin
            s_d.armed = 1'b0;
        end else if (halt_req) begin
            s_d.armed = 1'b0;
        end else if (s_q.seq_en && hit_pad[s_q.seq_a]) begin
            s_d.armed = 1'b1;
        end
        if (cfg_we) begin
            for (int i = 0; i < N_ICMP; i++) begin
                if (cfg_addr == CFG_AW'(int'(OFS_ICMP) + i))
                    s_d.icmp[i] = cfg_wdata[PC_W-1:0];
            end
            for (int j = 0; j < N_WATCH; j++) begin
                if (cfg_addr == CFG_AW'(int'(OFS_WADDR) + j))
                    s_d.waddr[j] = cfg_wdata[DA_W-1:0];
                if (cfg_addr == CFG_AW'(int'(OFS_WVAL) + j))
                    s_d.wval[j] = cfg_wdata[DV_W-1:0];
                if (cfg_addr == CFG_AW'(int'(OFS_WCTL) + j))
                    s_d.wctl[j] = wctl_t'(cfg_wdata[2:0]);
            end
            if (cfg_addr == OFS_EN)
                s_d.en = cfg_wdata[N_BASE-1:0];
            if (cfg_addr == OFS_SEQ) begin
                s_d.seq_en = cfg_wdata[0];
                s_d.seq_a  = cfg_wdata[8 +: IDX_W];
                s_d.seq_b  = cfg_wdata[16 +: IDX_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R9: a stopped core never sees a halt request
    a_r9_stopped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        core_stopped |-> !halt_req);

    // R7: any halt drops the armed flag
    a_r7_halt_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |=> !s_q.armed);

    // R7: rewriting the sequencer drops the armed flag
    a_r7_seqwrite_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == OFS_SEQ) |=> !s_q.armed);

    // R6: a sequencer halt is only possible once armed
    a_r6_seq_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req && halt_idx == IDX_W'(SEQ_IDX)) |-> s_q.armed);

    // R8: no firing source below the reported index
    a_r8_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |-> ((fire_vec & ~({N_SRC{1'b1}} << halt_idx)) == '0));

    // R10: index reads zero when idle
    a_r10_idle_idx: assert property (@(posedge clk) disable iff (!rst_n)
        !halt_req |-> (halt_idx == '0));

endmodule

// File: tb/test_bkpt_watch_unit.sv
`timescale 1ns/100ps
module test_bkpt_watch_unit;

    localparam int NI = 4, NW = 2, NE = 2;
    localparam int NB = NI + NW + NE;
    localparam int SEQ = NB;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        core_stopped = 1'b0;
    logic [31:0] pc = 32'h0000_FFF0;
    logic [31:0] dacc_addr = '0;
    logic [31:0] dacc_data = '0;
    logic        dacc_rd = 1'b0, dacc_wr = 1'b0;
    logic [1:0]  ext_evt = '0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        halt_req;
    logic [3:0]  halt_idx;

    int n_cmp = 0, n_fail = 0;
    bit done = 0;

    // behavioural reference state
    logic [31:0] m_icmp [NI];
    logic [31:0] m_waddr [NW];
    logic [31:0] m_wval [NW];
    logic [2:0]  m_wctl [NW];
    logic [7:0]  m_en;
    bit          m_seq_en, m_armed;
    int          m_a, m_b;

    always #2.5 clk = ~clk;

    bkpt_watch_unit i_bkpt_watch_unit (
        .clk(clk), .rst_n(rst_n), .core_stopped(core_stopped), .pc(pc),
        .dacc_addr(dacc_addr), .dacc_data(dacc_data), .dacc_rd(dacc_rd),
        .dacc_wr(dacc_wr), .ext_evt(ext_evt), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .halt_req(halt_req), .halt_idx(halt_idx)
    );

    task automatic model_reset();
        for (int i = 0; i < NI; i++) m_icmp[i] = '0;
        for (int j = 0; j < NW; j++) begin m_waddr[j] = '0; m_wval[j] = '0; m_wctl[j] = '0; end
        m_en = '0; m_seq_en = 0; m_armed = 0; m_a = 0; m_b = 0;
    endtask

    task automatic step(input string tag);
        bit hit [NB];
        bit exp_h, nxt_arm;
        int exp_i;
        @(negedge clk);
        for (int k = 0; k < NB; k++) hit[k] = 0;
        if (!core_stopped) begin
            for (int i = 0; i < NI; i++) hit[i] = (pc == m_icmp[i]);
            for (int j = 0; j < NW; j++) begin
                bit dir, vok;
                dir = (dacc_rd && m_wctl[j][0]) || (dacc_wr && m_wctl[j][1]);
                vok = !m_wctl[j][2] || (dacc_data == m_wval[j]);
                hit[NI + j] = dir && vok && (dacc_addr == m_waddr[j]);
            end
            for (int e = 0; e < NE; e++) hit[NI + NW + e] = ext_evt[e];
        end
        exp_h = 0; exp_i = 0;
        for (int k = 0; k < NB; k++)
            if (!exp_h && hit[k] && m_en[k]) begin exp_h = 1; exp_i = k; end
        if (!exp_h && m_seq_en && m_armed && m_b < NB && hit[m_b]) begin
            exp_h = 1; exp_i = SEQ;
        end
        if (!rst_n) begin exp_h = 0; exp_i = 0; end
        n_cmp++;
        if (halt_req !== exp_h || halt_idx !== 4'(exp_i)) begin
            n_fail++;
            $display("FAIL %s: halt=%0b idx=%0d expected halt=%0b idx=%0d",
                     tag, halt_req, halt_idx, exp_h, exp_i);
        end
        nxt_arm = m_armed;
        if (cfg_we && cfg_addr == 8'h21) nxt_arm = 0;
        else if (exp_h) nxt_arm = 0;
        else if (m_seq_en && m_a < NB && hit[m_a]) nxt_arm = 1;
        @(posedge clk);
        if (!rst_n) model_reset();
        else begin
            m_armed = nxt_arm;
            if (cfg_we) begin
                for (int i = 0; i < NI; i++) if (cfg_addr == 8'(i)) m_icmp[i] = cfg_wdata;
                for (int j = 0; j < NW; j++) begin
                    if (cfg_addr == 8'(16 + j)) m_waddr[j] = cfg_wdata;
                    if (cfg_addr == 8'(20 + j)) m_wval[j] = cfg_wdata;
                    if (cfg_addr == 8'(24 + j)) m_wctl[j] = cfg_wdata[2:0];
                end
                if (cfg_addr == 8'h20) m_en = cfg_wdata[7:0];
                if (cfg_addr == 8'h21) begin
                    m_seq_en = cfg_wdata[0];
                    m_a = int'(cfg_wdata[12:8]);
                    m_b = int'(cfg_wdata[20:16]);
                end
            end
        end
        #1;
    endtask

    task automatic idle();
        pc = 32'h0000_FFF0; dacc_rd = 0; dacc_wr = 0; ext_evt = '0;
        core_stopped = 0; dacc_addr = '0; dacc_data = '0;
    endtask

    task automatic cfg(input logic [7:0] a, input logic [31:0] d, input string tag);
        cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        step(tag);
        cfg_we = 0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R10 watchdog: cycles=20000 expected finish earlier");
            summary();
            $finish;
        end
    end

    initial begin
        model_reset();
        // R10: reset state
        repeat (3) step("R10 in reset");
        rst_n = 1;
        #1;
        pc = 32'h0;
        step("R10 idle after reset, pc 0 matches zero regs but disabled");
        idle();

        // R11 / R1 instruction comparators
        cfg(8'h00, 32'h0000_0100, "R11 write icmp0");
        cfg(8'h01, 32'h0000_0100, "R11 write icmp1");
        cfg(8'h02, 32'h0000_0200, "R11 write icmp2");
        pc = 32'h100; step("R2 enables still clear");
        idle();
        cfg(8'h20, 32'h05, "R11 enable icmp0 icmp2");
        pc = 32'h100; step("R1 pc hits icmp0");
        pc = 32'h200; step("R1 pc hits icmp2");
        pc = 32'h104; step("R1 no match");
        idle();
        cfg(8'h20, 32'h07, "R11 enable icmp0..2");
        pc = 32'h100; step("R8 duplicate address lowest wins");
        idle();
        cfg(8'h20, 32'h06, "R2 disable icmp0");
        pc = 32'h100; step("R2 disabled icmp0 skipped, icmp1 reported");
        core_stopped = 1; step("R9 stopped core ignores pc");
        idle();

        // R3 / R4 access comparators
        cfg(8'h10, 32'h0000_4000, "R11 write waddr0");
        cfg(8'h14, 32'h0000_00A5, "R11 write wval0");
        cfg(8'h18, 32'h1, "R3 read-only");
        cfg(8'h20, 32'h10, "R11 enable watch0");
        dacc_addr = 32'h4000; dacc_rd = 1; step("R3 read matches 01");
        dacc_rd = 0; dacc_wr = 1; step("R3 write ignored by 01");
        idle();
        cfg(8'h18, 32'h2, "R3 write-only");
        dacc_addr = 32'h4000; dacc_wr = 1; step("R3 write matches 10");
        dacc_wr = 0; dacc_rd = 1; step("R3 read ignored by 10");
        idle();
        cfg(8'h18, 32'h3, "R3 either");
        dacc_addr = 32'h4000; dacc_rd = 1; step("R3 read matches 11");
        dacc_rd = 0; dacc_wr = 1; step("R3 write matches 11");
        dacc_addr = 32'h4004; step("R3 other address no match");
        idle();
        cfg(8'h18, 32'h0, "R3 never");
        dacc_addr = 32'h4000; dacc_rd = 1; dacc_wr = 1; step("R3 code 00 never matches");
        idle();
        cfg(8'h18, 32'h7, "R4 value compare on");
        dacc_addr = 32'h4000; dacc_wr = 1; dacc_data = 32'hA5; step("R4 value equal");
        dacc_data = 32'h5A; step("R4 value differs");
        idle();
        cfg(8'h18, 32'h3, "R4 value compare off");
        dacc_addr = 32'h4000; dacc_wr = 1; dacc_data = 32'h5A; step("R4 value ignored");
        idle();

        // R5 events
        cfg(8'h20, 32'h40, "R11 enable event0");
        ext_evt = 2'b01; step("R5 event0 enabled");
        ext_evt = 2'b10; step("R5 event1 disabled");
        idle();
        cfg(8'h20, 32'h42, "R11 enable icmp1 and event0");
        pc = 32'h100; ext_evt = 2'b01; step("R8 instruction beats event");
        idle();

        // R6 / R7 sequencer: A = event0 (6), B = event1 (7), no direct enables
        cfg(8'h20, 32'h00, "R6 direct enables off");
        cfg(8'h21, 32'h0007_0601, "R6 sequencer A=6 B=7");
        ext_evt = 2'b10; step("R6 B before A no halt");
        ext_evt = 2'b01; step("R6 A arms, no halt");
        ext_evt = 2'b00; step("R6 idle while armed");
        ext_evt = 2'b10; step("R6 B while armed halts");
        step("R7 B again after halt no halt");
        ext_evt = 2'b01; step("R6 A re-arms");
        idle();
        cfg(8'h21, 32'h0007_0601, "R7 rewrite sequencer disarms");
        ext_evt = 2'b10; step("R7 B after rewrite no halt");
        ext_evt = 2'b01; core_stopped = 1; step("R9 A while stopped cannot arm");
        core_stopped = 0; ext_evt = 2'b10; step("R9 B after stopped A no halt");
        ext_evt = 2'b01; step("R6 arm again");
        ext_evt = 2'b00;
        cfg(8'h20, 32'h02, "R7 enable icmp1");
        pc = 32'h100; step("R7 direct halt while armed");
        idle();
        ext_evt = 2'b10; step("R7 B after direct halt no halt");
        ext_evt = 2'b11; step("R6 A and B together unarmed no halt");
        ext_evt = 2'b10; step("R6 B after simultaneous arm halts");
        idle();
        step("R10 idle index zero");

        done = 1;
        summary();
        $finish;
    end

endmodule